// File: doc/BRIEF.md
# USB Bus Supply Detect and Regulator Sequencer

This block watches a digitised sample of the USB bus supply voltage and decides whether a usable bus supply is present. Separate rising and falling thresholds are applied, so a level that wanders inside the band between them does not toggle the result. The block then sequences the dedicated 3.3 V USB regulator. The regulator enable is raised only while the USB peripheral is enabled and the bus supply is present. Readiness is declared after a worst-case settling time, measured in microsecond ticks.

Three sticky event flags report the transitions: supply detected, supply removed and regulator power ready. Each flag has its own interrupt enable, and the interrupt output combines them. If the supply appears while the system is off, the block issues a one-cycle wake request and sets a sticky wake-reason flag.

The control is a four-state machine:
- `ST_NOBUS`: no supply.
- `ST_BUSIDLE`: supply present, regulator off.
- `ST_SETTLE`: regulator on, settling time running.
- `ST_READY`: regulator output usable.

Its transitions are:
- attach: `ST_NOBUS` to `ST_BUSIDLE`, or straight to `ST_SETTLE` when the peripheral is already enabled.
- power-up: `ST_BUSIDLE` to `ST_SETTLE`.
- settled: `ST_SETTLE` to `ST_READY`.
- disable: `ST_SETTLE` or `ST_READY` to `ST_BUSIDLE`.
- detach: any state to `ST_NOBUS`.

Top module: `usb_supply_seq`

## Requirements
- R1: The detect state (status bit 0) is set by the first clock edge at which `vbus_lvl` is at or above `RISE_TH` while the detect state is 0. A level of `RISE_TH-1` never sets it.
- R2: While the detect state is 1, it stays 1 for any level at or above `FALL_TH`. It clears at the first edge at which `vbus_lvl` is below `FALL_TH`.
- R3: `reg_en` is high only in `ST_SETTLE` and `ST_READY`. Power-up happens one edge after both the detect state and `usb_en` are high. `reg_en` drops one edge after either of them goes low.
- R4: Status bit 1 (ready) rises at the edge that captures the `SETTLE_US`-th `us_tick` counted since `reg_en` rose. No tick means no progress. Leaving `ST_SETTLE` restarts the count from zero.
- R5: The status bit layout is bit 0 = bus supply present (1) or absent (0), and bit 1 = regulator settled (1).
- R6: The event flag layout is bit 0 = detected, bit 1 = removed, bit 2 = power ready. Each flag is set one edge after, respectively, status bit 0 rises, status bit 0 falls, or status bit 1 rises.
- R7: Each event flag stays set until an `evt_clr` pulse on its bit. A set in the same cycle wins over a clear.
- R8: `irq` is the OR of `evt_flags & irq_en`, and follows both signals in the same cycle.
- R9: When status bit 0 rises while `sys_off` is high, `wake_req` pulses for one cycle together with the detected flag setting, and `wake_reason` is set. `wake_reason` stays set until a `wake_clr` pulse. Without `sys_off`, neither output reacts.
- R10: In reset, all outputs are 0 and the machine is in `ST_NOBUS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vbus_lvl | input | VW | Digitised bus supply sample |
| usb_en | input | 1 | USB peripheral enabled |
| sys_off | input | 1 | System is in the off state |
| us_tick | input | 1 | One-cycle microsecond tick |
| evt_clr | input | 3 | Per-flag clear pulse |
| irq_en | input | 3 | Per-flag interrupt enable |
| wake_clr | input | 1 | Clear pulse for the wake reason |
| evt_flags | output | 3 | Sticky event flags |
| status | output | 2 | {ready, present} |
| reg_en | output | 1 | USB regulator enable |
| wake_req | output | 1 | One-cycle wake/reset request |
| wake_reason | output | 1 | Sticky bus-supply wake reason |
| irq | output | 1 | Interrupt request |

## Verification
Timing is counted from the clock edge that samples a change on `vbus_lvl`:
- Status bit 0 moves at that edge.
- The detected and removed flags, and `wake_req`, follow one edge later.
- `reg_en` rises one edge after the detect state, if `usb_en` was already high, and falls one edge after the detect state or `usb_en` is lost.
- Ready appears at the edge that takes the `SETTLE_US`-th tick, and the power-ready flag appears one edge after that.
- `irq` is combinational.

The bench updates a reference model from these rules at every rising edge and compares all outputs at the following falling edge. Every expected value is therefore checked in the cycle it becomes due. Directed threshold corner cases precede a long random phase in which the level is drawn around both thresholds.

// File: rtl/usb_sup_pkg.sv
package usb_sup_pkg;
    localparam int NEV = 3;
    localparam int EV_DET = 0;
    localparam int EV_REM = 1;
    localparam int EV_RDY = 2;

    typedef enum logic [1:0] {
        ST_NOBUS   = 2'd0,
        ST_BUSIDLE = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_READY   = 2'd3
    } sup_state_e;
endpackage

// File: rtl/usb_vbus_hyst.sv
module usb_vbus_hyst #(
    parameter int VW      = 8,
    parameter int RISE_TH = 80,
    parameter int FALL_TH = 72
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] lvl,
    output logic          det,
    output logic          rise,
    output logic          fall
);
    localparam logic [VW-1:0] RISE_L = VW'(RISE_TH);
    localparam logic [VW-1:0] FALL_L = VW'(FALL_TH);

    logic det_q;
    logic det_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q <= 1'b0;
            det_d <= 1'b0;
        end else begin
            det_d <= det_q;
            if (!det_q && lvl >= RISE_L) begin
                det_q <= 1'b1;
            end else if (det_q && lvl < FALL_L) begin
                det_q <= 1'b0;
            end
        end
    end

    assign det  = det_q;
    assign rise = det_q && !det_d;
    assign fall = !det_q && det_d;

    // R1: a level below the rising threshold cannot raise detection
    p_no_early_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_q && lvl < RISE_L) |=> !det_q);

    // R2: inside the band a present supply is held
    p_hyst_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q && lvl >= FALL_L) |=> det_q);
endmodule

// File: rtl/usb_settle_timer.sv
module usb_settle_timer #(
    parameter int SETTLE_US = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(SETTLE_US + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_US - 1);

    logic [CW-1:0] cnt;

    assign done = run && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the count never passes the settling limit
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R4: without a tick the count holds while running
    p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (cnt == $past(cnt)) || !$past(run));
endmodule

// File: rtl/usb_evt_flags.sv
module usb_evt_flags #(
    parameter int N = usb_sup_pkg::NEV
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (set[i]) begin
                flags[i] <= 1'b1;
            end else if (clr[i]) begin
                flags[i] <= 1'b0;
            end
        end

        // R7: a pending flag survives any cycle without its clear
        p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr[i]) |=> flags[i]);

        // R7: a set in the same cycle as a clear wins
        p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
    end
endmodule

// File: rtl/usb_supply_seq.sv
module usb_supply_seq
    import usb_sup_pkg::*;
#(
    parameter int VW        = 8,
    parameter int RISE_TH   = 80,
    parameter int FALL_TH   = 72,
    parameter int SETTLE_US = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vbus_lvl,
    input  logic          usb_en,
    input  logic          sys_off,
    input  logic          us_tick,
    input  logic [2:0]    evt_clr,
    input  logic [2:0]    irq_en,
    input  logic          wake_clr,
    output logic [2:0]    evt_flags,
    output logic [1:0]    status,
    output logic          reg_en,
    output logic          wake_req,
    output logic          wake_reason,
    output logic          irq
);
    sup_state_e state, state_nx;
    logic det, det_rise, det_fall;
    logic settle_done;
    logic rdy, rdy_d;
    logic run;
    logic [NEV-1:0] ev_set;

    usb_vbus_hyst #(
        .VW(VW), .RISE_TH(RISE_TH), .FALL_TH(FALL_TH)
    ) i_hyst (
        .clk(clk), .rst_n(rst_n), .lvl(vbus_lvl),
        .det(det), .rise(det_rise), .fall(det_fall)
    );

    usb_settle_timer #(
        .SETTLE_US(SETTLE_US)
    ) i_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(us_tick), .done(settle_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_NOBUS;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_NOBUS: begin
                if (det) state_nx = usb_en ? ST_SETTLE : ST_BUSIDLE;
            end
            ST_BUSIDLE: begin
                if (!det)       state_nx = ST_NOBUS;
                else if (usb_en) state_nx = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (!det)            state_nx = ST_NOBUS;
                else if (!usb_en)    state_nx = ST_BUSIDLE;
                else if (settle_done) state_nx = ST_READY;
            end
            ST_READY: begin
                if (!det)         state_nx = ST_NOBUS;
                else if (!usb_en) state_nx = ST_BUSIDLE;
            end
            default: state_nx = ST_NOBUS;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        run    = 1'b0;
        reg_en = 1'b0;
        rdy    = 1'b0;
        unique case (state)
            ST_NOBUS, ST_BUSIDLE: ;
            ST_SETTLE: begin
                run    = 1'b1;
                reg_en = 1'b1;
            end
            ST_READY: begin
                reg_en = 1'b1;
                rdy    = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_d       <= 1'b0;
            wake_req    <= 1'b0;
            wake_reason <= 1'b0;
        end else begin
            rdy_d    <= rdy;
            wake_req <= det_rise && sys_off;
            if (det_rise && sys_off) begin
                wake_reason <= 1'b1;
            end else if (wake_clr) begin
                wake_reason <= 1'b0;
            end
        end
    end

    assign ev_set[EV_DET] = det_rise;
    assign ev_set[EV_REM] = det_fall;
    assign ev_set[EV_RDY] = rdy && !rdy_d;

    usb_evt_flags #(.N(NEV)) i_flags (
        .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(evt_clr), .flags(evt_flags)
    );

    assign status = {rdy, det};
    assign irq    = |(evt_flags & irq_en);

    // R3: losing the peripheral enable removes the regulator enable next edge
    p_regen_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !usb_en) |=> !reg_en);

    // R3: losing the supply removes the regulator enable next edge
    p_regen_needs_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !status[0]) |=> !reg_en);

    // R4: readiness only appears after the regulator was already on
    p_ready_after_regen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(reg_en));

    // R9: a wake reason is only recorded while the system was off
    p_wake_only_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_reason) |-> $past(sys_off));

    // R9: the wake request lasts a single cycle
    p_wake_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);
endmodule

// File: tb/test_usb_supply_seq.sv
module test_usb_supply_seq;
    localparam int VW     = 8;
    localparam int RISE   = 80;
    localparam int FALL   = 72;
    localparam int SETTLE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] vbus_lvl = '0;
    logic          usb_en = 1'b0;
    logic          sys_off = 1'b0;
    logic          us_tick = 1'b0;
    logic [2:0]    evt_clr = '0;
    logic [2:0]    irq_en = '0;
    logic          wake_clr = 1'b0;
    logic [2:0]    evt_flags;
    logic [1:0]    status;
    logic          reg_en, wake_req, wake_reason, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    usb_supply_seq #(
        .VW(VW), .RISE_TH(RISE), .FALL_TH(FALL), .SETTLE_US(SETTLE)
    ) i_usb_supply_seq (
        .clk(clk), .rst_n(rst_n), .vbus_lvl(vbus_lvl), .usb_en(usb_en),
        .sys_off(sys_off), .us_tick(us_tick), .evt_clr(evt_clr),
        .irq_en(irq_en), .wake_clr(wake_clr), .evt_flags(evt_flags),
        .status(status), .reg_en(reg_en), .wake_req(wake_req),
        .wake_reason(wake_reason), .irq(irq)
    );

    // reference model: 0 nobus, 1 bus idle, 2 settle, 3 ready
    bit       m_det, m_det_d, m_rdy_d, m_wreq, m_wrsn;
    int       m_st, m_cnt;
    bit [2:0] m_flag;

    function automatic int fsm_next(int st, bit det, bit en, bit dn);
        case (st)
            0: return det ? (en ? 2 : 1) : 0;
            1: return !det ? 0 : (en ? 2 : 1);
            2: return !det ? 0 : (!en ? 1 : (dn ? 3 : 2));
            default: return !det ? 0 : (!en ? 1 : 3);
        endcase
    endfunction

    function automatic bit det_next(bit det, int lvl);
        if (!det) return lvl >= RISE;
        return !(lvl < FALL);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_det = 0; m_det_d = 0; m_rdy_d = 0; m_wreq = 0; m_wrsn = 0;
            m_st = 0; m_cnt = 0; m_flag = '0;
        end else begin
            bit dn, rise, fall, rdy;
            bit [2:0] setv;
            int nst;
            dn   = (m_st == 2) && us_tick && (m_cnt == SETTLE - 1);
            rise = m_det && !m_det_d;
            fall = !m_det && m_det_d;
            rdy  = (m_st == 3);
            setv = {rdy && !m_rdy_d, fall, rise};
            nst  = fsm_next(m_st, m_det, usb_en, dn);
            if (m_st != 2 || dn) m_cnt = 0;
            else if (us_tick) m_cnt = m_cnt + 1;
            m_flag  = setv | (m_flag & ~evt_clr);
            m_wreq  = rise && sys_off;
            if (rise && sys_off) m_wrsn = 1;
            else if (wake_clr) m_wrsn = 0;
            m_rdy_d = rdy;
            m_det_d = m_det;
            m_det   = det_next(m_det, int'(vbus_lvl));
            m_st    = nst;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        chk("R1/R2/R5 status present", int'(status[0]), int'(m_det));
        chk("R4/R5 status ready", int'(status[1]), int'(m_st == 3));
        chk("R3 reg_en", int'(reg_en), int'(m_st >= 2));
        chk("R6/R7 evt_flags", int'(evt_flags), int'(m_flag));
        chk("R8 irq", int'(irq), int'(|(m_flag & irq_en)));
        chk("R9 wake_req", int'(wake_req), int'(m_wreq));
        chk("R9 wake_reason", int'(wake_reason), int'(m_wrsn));
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cycles++;
            compare_all();
            evt_clr  = '0;
            wake_clr = 1'b0;
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(1234);
        // R10: reset state
        step(3);
        chk("R10 reset flags", int'(evt_flags), 0);
        chk("R10 reset status", int'(status), 0);
        chk("R10 reset reg_en", int'(reg_en), 0);
        rst_n = 1'b1;
        // R1: one below the rising threshold never detects
        vbus_lvl = VW'(RISE - 1);
        step(5);
        chk("R1 below rise", int'(status[0]), 0);
        vbus_lvl = VW'(RISE);
        step(1);
        chk("R1 at rise", int'(status[0]), 1);
        step(1);
        chk("R6 detected flag", int'(evt_flags[0]), 1);
        // R2: hold at the falling threshold, drop one below it
        vbus_lvl = VW'(FALL);
        step(4);
        chk("R2 hold at fall", int'(status[0]), 1);
        vbus_lvl = VW'(FALL - 1);
        step(1);
        chk("R2 drop below fall", int'(status[0]), 0);
        step(1);
        chk("R6 removed flag", int'(evt_flags[1]), 1);
        evt_clr = 3'b111;
        step(1);
        chk("R7 clear", int'(evt_flags), 0);
        // R3/R4: power-up with a tick stall
        usb_en = 1'b1;
        vbus_lvl = 8'd100;
        step(2);
        chk("R3 reg_en on", int'(reg_en), 1);
        step(30);
        chk("R4 no ticks no ready", int'(status[1]), 0);
        us_tick = 1'b1;
        step(SETTLE - 1);
        chk("R4 one tick short", int'(status[1]), 0);
        step(1);
        chk("R4 ready", int'(status[1]), 1);
        us_tick = 1'b0;
        irq_en = 3'b100;
        step(1);
        chk("R8 irq pwrrdy", int'(irq), 1);
        usb_en = 1'b0;
        step(1);
        chk("R3 reg_en off", int'(reg_en), 0);
        // R9: wake from off
        vbus_lvl = '0;
        sys_off = 1'b1;
        step(3);
        vbus_lvl = 8'd200;
        step(2);
        chk("R9 wake pulse", int'(wake_req), 1);
        step(1);
        chk("R9 wake reason held", int'(wake_reason), 1);
        wake_clr = 1'b1;
        step(1);
        chk("R9 wake cleared", int'(wake_reason), 0);
        sys_off = 1'b0;
        // random phase
        for (int i = 0; i < 30000; i++) begin
            if ($urandom_range(0, 47) == 0) begin
                case ($urandom_range(0, 6))
                    0: vbus_lvl = '0;
                    1: vbus_lvl = VW'(FALL - 1);
                    2: vbus_lvl = VW'(FALL);
                    3: vbus_lvl = VW'((RISE + FALL) / 2);
                    4: vbus_lvl = VW'(RISE - 1);
                    5: vbus_lvl = VW'(RISE);
                    default: vbus_lvl = 8'd255;
                endcase
            end
            if ($urandom_range(0, 199) == 0) usb_en = ~usb_en;
            if ($urandom_range(0, 299) == 0) sys_off = ~sys_off;
            if ($urandom_range(0, 49) == 0) irq_en = 3'($urandom);
            us_tick = ($urandom_range(0, 1) == 0);
            step(1);
            if ($urandom_range(0, 31) == 0) evt_clr = 3'($urandom);
            if ($urandom_range(0, 99) == 0) wake_clr = 1'b1;
        end
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule